// File: doc/BRIEF.md
# Processor Address Decoder with One-Way Boot Remap

This block sits between the processor's address bus and the on-chip memory, the external-bus controller and the peripheral bridge. Every access is classified as combinational logic in the same cycle. The lowest 4 MB goes to on-chip SRAM. The top 4 MB goes to the peripheral bridge. Everything in between belongs to the external bus. In the external region, up to eight chip-select banks are matched against a base and a power-of-two size supplied by the external-bus configuration. An external access that matches no bank raises an abort. Accesses to SRAM or to peripherals never abort, even at holes in those regions.

Address zero starts out mapped to the boot device on chip select 0, so the processor can fetch its reset vector from non-volatile storage. A single write of a one to the remap command moves the lowest window over to SRAM, after which software can rewrite the exception vectors. The remap cannot be undone except by reset. Before remap, all programmed banks are dormant. Chip select 0 answers only at address zero, and every other external access aborts. Peripheral accesses narrower than a word are promoted to word accesses by clearing the two lowest address bits. The peripheral region is further split into 16 KB slots, and the top 4 KB is reserved for the interrupt controller.

Top module: `memmap_decode`

## Requirements
- R1: With `acc_valid` high, an address below 0x0040_0000 is internal, an address at or above 0xFFC0_0000 raises `sel_periph`, and any other address is external. At most one of `sel_sram`, `sel_periph` and "any `cs_sel` bit" is high.
- R2: After reset the block is in boot mapping. A cycle with `remap_wr` and `remap_din` both high switches to remapped mapping from the next cycle on. A `remap_wr` with `remap_din` low has no effect.
- R3: Once remapped, the mapping stays remapped whatever `remap_wr`/`remap_din` do, until `rst_n` is asserted, which restores boot mapping.
- R4: In boot mapping, an internal address below 0x0010_0000 raises `cs_sel[0]` and not `sel_sram`, and the rest of the internal region raises `sel_sram`. In remapped mapping, the whole internal region raises `sel_sram` only.
- R5: In boot mapping, every external-region access raises `abort` and no `cs_sel` bit, whatever the bank configuration.
- R6: In remapped mapping, bank i matches when `bank_en[i]` is set and the address lies in the naturally aligned window that contains the base. The base is `bank_base[12*i +: 12]`, giving address bits 31:20. The size code `bank_szc[3*i +: 3]` selects 1, 2, 4, 8 or 16 MB for codes 0 to 4, and codes above 4 mean 16 MB. When several banks match, the lowest index wins, so `cs_sel` is one-hot or zero.
- R7: `abort` is high exactly for a valid external-region access that no bank claims. It is never raised for internal or peripheral addresses.
- R8: For a valid peripheral access, `out_addr` equals `acc_addr` with bits 1:0 cleared and `out_size` is 2 (word). For other valid accesses, `out_addr` and `out_size` equal `acc_addr` and `acc_size` (0 byte, 1 halfword, 2 word).
- R9: For a peripheral access, `periph_slot` is address bits 21:14. `intc_hit` is high when bits 21:12 are all ones. `periph_hit` is high when bits 21:14 are not all ones. Neither causes an abort.
- R10: With `acc_valid` low, `sel_sram`, `sel_periph`, `cs_sel`, `periph_hit`, `intc_hit`, `out_wr` and `abort` are all low. Otherwise `out_wr` follows `acc_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the remap state |
| remap_wr | input | 1 | Remap command write strobe |
| remap_din | input | 1 | Data bit written with the remap command |
| acc_valid | input | 1 | Processor access present this cycle |
| acc_addr | input | 32 | Processor byte address |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_wr | input | 1 | Access is a write |
| bank_en | input | 8 | Per-bank enable |
| bank_base | input | 96 | Per-bank base, address bits 31:20, 12 bits per bank |
| bank_szc | input | 24 | Per-bank log2 size code above 1 MB, 3 bits per bank |
| sel_sram | output | 1 | On-chip SRAM selected |
| sel_periph | output | 1 | Peripheral region selected |
| cs_sel | output | 8 | External chip selects, active high, one-hot or zero |
| periph_slot | output | 8 | Peripheral 16 KB slot index |
| periph_hit | output | 1 | Regular peripheral slot addressed |
| intc_hit | output | 1 | Interrupt-controller 4 KB window addressed |
| out_addr | output | 32 | Address forwarded to the selected target |
| out_size | output | 2 | Size forwarded to the selected target |
| out_wr | output | 1 | Qualified write flag |
| abort | output | 1 | Undefined external address |

## Verification
The only state in the block is the remap flag. If it is wrong, the ports show it in the first valid access to the bottom megabyte, which lands on `cs_sel[0]` instead of `sel_sram` or the reverse. The same wrong flag also shows on any external access, which aborts when it should reach a bank or reaches a bank when it should abort. The bench therefore probes address zero and a bank address right after each remap write, each ignored write, and each reset. The decode itself is combinational, so a faulty comparator, size clamp or priority order is visible in the same cycle as the access. Boundary addresses on each region edge and each bank edge expose it immediately.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

endpackage

// File: rtl/mm_remap_flag.sv
module mm_remap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic remapped
);

  logic flag_q;
  logic flag_en;

  always_comb begin
    flag_en = set_req & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= 1'b1;
    end
  end

  assign remapped = flag_q;

  // R2: a command with data one takes effect on the next cycle
  p_remap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> remapped);

  // R2: nothing else sets the flag
  p_remap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && !set_req) |=> !remapped);

  // R3: only reset leaves the remapped state
  p_remap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |=> remapped);

endmodule

// File: rtl/mm_bank_match.sv
module mm_bank_match #(
  parameter int BASE_W   = 12,
  parameter int SZC_W    = 3,
  parameter int MAX_CODE = 4
) (
  input  logic [BASE_W-1:0] addr_hi,
  input  logic              armed,
  input  logic              bank_en,
  input  logic [BASE_W-1:0] base,
  input  logic [SZC_W-1:0]  szc,
  output logic              hit
);

  localparam logic [SZC_W-1:0] CODE_CAP = SZC_W'(MAX_CODE);

  logic [SZC_W-1:0]  code_eff;
  logic [BASE_W-1:0] keep_mask;
  logic [BASE_W-1:0] diff;

  always_comb begin
    code_eff  = (szc > CODE_CAP) ? CODE_CAP : szc;
    keep_mask = {BASE_W{1'b1}} << code_eff;
    diff      = (addr_hi ^ base) & keep_mask;
    hit       = armed & bank_en & (diff == '0);
  end

endmodule

// File: rtl/mm_periph_decode.sv
module mm_periph_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LOG2 = 22,
  parameter int SLOT_LOG2  = 14,
  parameter int INTC_LOG2  = 12
) (
  input  logic                             in_region,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [1:0]                       size,
  output logic [REGION_LOG2-SLOT_LOG2-1:0] slot,
  output logic                             slot_hit,
  output logic                             intc_hit,
  output logic [ADDR_W-1:0]                addr_o,
  output logic [1:0]                       size_o
);

  localparam int SLOT_W = REGION_LOG2 - SLOT_LOG2;
  localparam int INTC_W = REGION_LOG2 - INTC_LOG2;

  logic [INTC_W-1:0] intc_field;

  always_comb begin
    slot       = addr[REGION_LOG2-1:SLOT_LOG2];
    intc_field = addr[REGION_LOG2-1:INTC_LOG2];
    intc_hit   = in_region & (&intc_field);
    // the topmost slot is reserved for the interrupt controller window
    slot_hit   = in_region & ~(&slot);
    if (in_region) begin
      addr_o = {addr[ADDR_W-1:2], 2'b00};
      size_o = SZ_WORD;
    end else begin
      addr_o = addr;
      size_o = size;
    end
  end

  initial begin
    a_slot_fit: assert (SLOT_W > 0 && INTC_W >= SLOT_W);
  end

endmodule

// File: rtl/memmap_decode.sv
module memmap_decode #(
  parameter int NCS           = 8,
  parameter int ADDR_W        = 32,
  parameter int INT_LOG2      = 22,
  parameter int BOOT_LOG2     = 20,
  parameter int BANK_MIN_LOG2 = 20,
  parameter int BANK_SZC_W    = 3,
  parameter int BANK_MAX_CODE = 4,
  parameter int PSLOT_LOG2    = 14,
  parameter int INTC_LOG2     = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     remap_wr,
  input  logic                                     remap_din,
  input  logic                                     acc_valid,
  input  logic [ADDR_W-1:0]                        acc_addr,
  input  logic [1:0]                               acc_size,
  input  logic                                     acc_wr,
  input  logic [NCS-1:0]                           bank_en,
  input  logic [NCS*(ADDR_W-BANK_MIN_LOG2)-1:0]    bank_base,
  input  logic [NCS*BANK_SZC_W-1:0]                bank_szc,
  output logic                                     sel_sram,
  output logic                                     sel_periph,
  output logic [NCS-1:0]                           cs_sel,
  output logic [INT_LOG2-PSLOT_LOG2-1:0]           periph_slot,
  output logic                                     periph_hit,
  output logic                                     intc_hit,
  output logic [ADDR_W-1:0]                        out_addr,
  output logic [1:0]                               out_size,
  output logic                                     out_wr,
  output logic                                     abort
);

  localparam int BASE_W = ADDR_W - BANK_MIN_LOG2;
  localparam int HI_W   = ADDR_W - INT_LOG2;
  localparam int BOOT_W = INT_LOG2 - BOOT_LOG2;

  logic            remapped;
  logic [HI_W-1:0] region_hi;
  logic            low_rgn, per_rgn, ext_rgn;
  logic            boot_hit;
  logic [NCS-1:0]  bank_raw;
  logic [NCS-1:0]  bank_pick;
  logic            slot_hit_w, intc_hit_w;

  mm_remap_flag u_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (remap_wr & remap_din),
    .remapped (remapped)
  );

  always_comb begin
    region_hi = acc_addr[ADDR_W-1:INT_LOG2];
    low_rgn   = (region_hi == '0);
    per_rgn   = &region_hi;
    ext_rgn   = ~low_rgn & ~per_rgn;
    boot_hit  = low_rgn & ~remapped &
                (acc_addr[INT_LOG2-1:BOOT_LOG2] == BOOT_W'(0));
  end

  for (genvar gi = 0; gi < NCS; gi++) begin : g_bank
    mm_bank_match #(
      .BASE_W   (BASE_W),
      .SZC_W    (BANK_SZC_W),
      .MAX_CODE (BANK_MAX_CODE)
    ) u_match (
      .addr_hi (acc_addr[ADDR_W-1:BANK_MIN_LOG2]),
      .armed   (remapped & ext_rgn),
      .bank_en (bank_en[gi]),
      .base    (bank_base[gi*BASE_W +: BASE_W]),
      .szc     (bank_szc[gi*BANK_SZC_W +: BANK_SZC_W]),
      .hit     (bank_raw[gi])
    );
  end

  // lowest-index bank wins when windows overlap
  always_comb begin
    logic taken;
    taken     = 1'b0;
    bank_pick = '0;
    for (int i = 0; i < NCS; i++) begin
      if (bank_raw[i] && !taken) begin
        bank_pick[i] = 1'b1;
        taken        = 1'b1;
      end
    end
  end

  mm_periph_decode #(
    .ADDR_W      (ADDR_W),
    .REGION_LOG2 (INT_LOG2),
    .SLOT_LOG2   (PSLOT_LOG2),
    .INTC_LOG2   (INTC_LOG2)
  ) u_periph (
    .in_region (per_rgn),
    .addr      (acc_addr),
    .size      (acc_size),
    .slot      (periph_slot),
    .slot_hit  (slot_hit_w),
    .intc_hit  (intc_hit_w),
    .addr_o    (out_addr),
    .size_o    (out_size)
  );

  always_comb begin
    sel_sram   = acc_valid & low_rgn & ~boot_hit;
    sel_periph = acc_valid & per_rgn;
    periph_hit = acc_valid & slot_hit_w;
    intc_hit   = acc_valid & intc_hit_w;
    out_wr     = acc_valid & acc_wr;
    abort      = acc_valid & ext_rgn & ~(|bank_raw);
    cs_sel     = '0;
    if (acc_valid) begin
      if (ext_rgn) cs_sel = bank_pick;
      else         cs_sel[0] = boot_hit;
    end
  end

  // R1: regions are exclusive
  p_region_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_sram, sel_periph, |cs_sel}) <= 1);

  // R4: boot window goes to chip select 0 before remap
  p_boot_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && acc_valid && low_rgn &&
     acc_addr[INT_LOG2-1:BOOT_LOG2] == BOOT_W'(0)) |-> (cs_sel[0] && !sel_sram));

  // R5: no bank answers before remap
  p_no_bank_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && acc_valid && ext_rgn) |-> (abort && cs_sel == '0));

  // R6: chip selects never overlap
  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  // R7: abort only in the external region with nothing selected
  p_abort_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (ext_rgn && cs_sel == '0 && !sel_sram && !sel_periph));

  // R8: peripheral accesses are word aligned words
  p_periph_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_periph |-> (out_addr[1:0] == 2'b00 && out_size == 2'd2 &&
                    out_addr[ADDR_W-1:2] == acc_addr[ADDR_W-1:2]));

  // R10: idle bus selects nothing
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!sel_sram && !sel_periph && cs_sel == '0 &&
                    !abort && !out_wr && !periph_hit && !intc_hit));

endmodule

// File: tb/memmap_decode_tb_top.sv
module memmap_decode_tb_top;

  localparam int NCS = 8;

  logic        clk;
  logic        rst_n;
  logic        remap_wr, remap_din;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        acc_wr;
  logic [7:0]  bank_en;
  logic [95:0] bank_base;
  logic [23:0] bank_szc;
  logic        sel_sram, sel_periph, periph_hit, intc_hit, out_wr, abort;
  logic [7:0]  cs_sel;
  logic [7:0]  periph_slot;
  logic [31:0] out_addr;
  logic [1:0]  out_size;

  memmap_decode dut_i (
    .clk(clk), .rst_n(rst_n), .remap_wr(remap_wr), .remap_din(remap_din),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wr(acc_wr), .bank_en(bank_en), .bank_base(bank_base),
    .bank_szc(bank_szc), .sel_sram(sel_sram), .sel_periph(sel_periph),
    .cs_sel(cs_sel), .periph_slot(periph_slot), .periph_hit(periph_hit),
    .intc_hit(intc_hit), .out_addr(out_addr), .out_size(out_size),
    .out_wr(out_wr), .abort(abort)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit m_remap = 1'b0;

  int e_en   [NCS] = '{1, 1, 1, 0, 1, 1, 1, 1};
  int e_base [NCS] = '{'h010, 'h020, 'h021, 'h030, 'h035, 'h800, 'hFFC, 'h004};
  int e_code [NCS] = '{4, 0, 1, 0, 7, 2, 0, 0};

  task automatic cmp(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%08h remap %0d)",
               tag, act, exp, acc_addr, m_remap);
    end
  endtask

  // behavioural reference of the address map
  task automatic check_now();
    longint unsigned a;
    int ex_sram, ex_per, ex_abort, ex_phit, ex_intc, ex_slot, ex_size;
    int ex_cs;
    longint unsigned ex_addr;
    a = longint'(acc_addr);
    ex_sram = 0; ex_per = 0; ex_abort = 0; ex_phit = 0; ex_intc = 0;
    ex_cs = 0; ex_slot = 0; ex_addr = a; ex_size = int'(acc_size);
    if (a < 64'h40_0000) begin
      if (!m_remap && a < 64'h10_0000) ex_cs = 1;
      else ex_sram = 1;
    end else if (a >= 64'hFFC0_0000) begin
      ex_per  = 1;
      ex_addr = a - (a % 4);
      ex_size = 2;
      ex_slot = int'((a - 64'hFFC0_0000) / 16384);
      ex_intc = (a >= 64'hFFFF_F000) ? 1 : 0;
      ex_phit = (ex_slot != 255) ? 1 : 0;
    end else if (!m_remap) begin
      ex_abort = 1;
    end else begin
      ex_abort = 1;
      for (int i = NCS - 1; i >= 0; i--) begin
        longint unsigned sz, lo;
        sz = 64'd1 << (20 + ((e_code[i] > 4) ? 4 : e_code[i]));
        lo = (longint'(e_base[i]) << 20);
        lo = (lo / sz) * sz;
        if (e_en[i] != 0 && a >= lo && a < lo + sz) begin
          ex_cs = 1 << i;
          ex_abort = 0;
        end
      end
    end
    if (!acc_valid) begin
      cmp("R10 idle selects", {sel_sram, sel_periph, cs_sel, abort, out_wr,
                               periph_hit, intc_hit}, 0);
    end else begin
      cmp("R1/R4 sram select", sel_sram, ex_sram);
      cmp("R1 periph select", sel_periph, ex_per);
      cmp("R4/R5/R6 chip selects", cs_sel, ex_cs);
      cmp("R5/R7 abort", abort, ex_abort);
      cmp("R8 forwarded address", out_addr, ex_addr);
      cmp("R8 forwarded size", out_size, ex_size);
      cmp("R10 write flag", out_wr, acc_wr);
      if (ex_per != 0) begin
        cmp("R9 periph slot", periph_slot, ex_slot);
        cmp("R9 periph hit", periph_hit, ex_phit);
        cmp("R9 intc hit", intc_hit, ex_intc);
      end
    end
  endtask

  // called at a falling edge with inputs already driven
  task automatic cyc();
    #3;
    check_now();
    @(posedge clk);
    if (rst_n && remap_wr && remap_din) m_remap = 1'b1;
    @(negedge clk);
    remap_wr  = 1'b0;
    remap_din = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic [1:0] sz, logic w);
    acc_valid = 1'b1;
    acc_addr  = a;
    acc_size  = sz;
    acc_wr    = w;
    cyc();
  endtask

  task automatic idle();
    acc_valid = 1'b0;
    acc_addr  = 32'h0;
    cyc();
  endtask

  task automatic cmd(logic d);
    remap_wr  = 1'b1;
    remap_din = d;
    acc_valid = 1'b0;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned s;
    rst_n = 1'b0; remap_wr = 1'b0; remap_din = 1'b0;
    acc_valid = 1'b0; acc_addr = '0; acc_size = 2'd2; acc_wr = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      bank_en[i]            = (e_en[i] != 0);
      bank_base[i*12 +: 12] = 12'(e_base[i]);
      bank_szc[i*3 +: 3]    = 3'(e_code[i]);
    end
    repeat (3) @(negedge clk);
    // R10: quiet outputs during and after reset
    check_now();
    rst_n = 1'b1;
    idle();

    // R4 / R5 in boot mapping
    acc(32'h0000_0000, 2'd2, 1'b0);
    acc(32'h000F_FFFF, 2'd0, 1'b1);
    acc(32'h0010_0000, 2'd2, 1'b0);
    acc(32'h003F_FFFC, 2'd1, 1'b1);
    acc(32'h0040_0000, 2'd2, 1'b0);
    acc(32'h0100_0000, 2'd2, 1'b0);
    acc(32'hFFBF_FFFF, 2'd0, 1'b0);
    // R8 / R9 peripheral decode
    acc(32'hFFC0_0001, 2'd0, 1'b1);
    acc(32'hFFC0_7FFE, 2'd1, 1'b0);
    acc(32'hFFFF_F003, 2'd0, 1'b0);
    acc(32'hFFFF_C010, 2'd2, 1'b1);
    acc(32'hFFFF_BFFF, 2'd0, 1'b0);

    // R2: a zero write does not remap
    cmd(1'b0);
    acc(32'h0000_0000, 2'd2, 1'b0);
    // R2: a one write remaps from the next cycle
    cmd(1'b1);
    acc(32'h0000_0000, 2'd2, 1'b0);
    acc(32'h000F_FFFC, 2'd2, 1'b0);
    // R3: further writes change nothing
    cmd(1'b0);
    acc(32'h0000_0010, 2'd2, 1'b0);

    // R6 / R7 bank windows, priority, clamp and holes
    acc(32'h0040_0000, 2'd2, 1'b0);
    acc(32'h004F_FFFF, 2'd2, 1'b0);
    acc(32'h0050_0000, 2'd2, 1'b0);
    acc(32'h0100_0000, 2'd2, 1'b0);
    acc(32'h01FF_FFFF, 2'd0, 1'b0);
    acc(32'h0200_0000, 2'd2, 1'b0);
    acc(32'h0210_0000, 2'd2, 1'b0);
    acc(32'h021F_FFFF, 2'd2, 1'b0);
    acc(32'h0220_0000, 2'd2, 1'b0);
    acc(32'h0300_0000, 2'd2, 1'b0);
    acc(32'h03FF_FFFF, 2'd2, 1'b0);
    acc(32'h8000_0000, 2'd2, 1'b1);
    acc(32'h803F_FFFF, 2'd2, 1'b1);
    acc(32'h8040_0000, 2'd2, 1'b1);
    acc(32'h7000_0000, 2'd2, 1'b0);
    acc(32'hFFBF_FFFF, 2'd2, 1'b0);
    acc(32'hFFC0_0002, 2'd1, 1'b0);
    idle();

    // pseudo-random sweep across all regions
    s = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      case (s[31:30])
        2'd0: a = {10'h0, s[21:0]};
        2'd1: a = {10'h3FF, s[21:0]};
        2'd2: a = {6'h0, s[25:0]};
        default: a = s;
      endcase
      if (s[7:0] == 8'h00) idle();
      else acc(a, 2'(s[9:8] % 3), s[10]);
    end

    // R3: reset returns to boot mapping
    rst_n = 1'b0;
    m_remap = 1'b0;
    acc_valid = 1'b0;
    #3;
    check_now();
    @(negedge clk);
    rst_n = 1'b1;
    acc(32'h0000_0000, 2'd2, 1'b0);
    acc(32'h0100_0000, 2'd2, 1'b0);
    cmd(1'b1);
    acc(32'h0100_0004, 2'd2, 1'b0);
    idle();

    finish_run();
  end

endmodule